// File: doc/BRIEF.md
# Multi-channel prescaled PWM generator

This block drives a set of pulse-width-modulated outputs that all run from one shared time base. Software programs it through a small 32-bit register window with word-aligned byte addresses. There is one duty register for each channel. A control register holds an 8-bit prescale value and a single run bit. A separate register holds an interrupt-enable flag, which is only stored.

The prescaler divides the input clock down to a local tick. An 8-bit count advances once per tick, so one period is always 256 ticks long. The only way to change the period is through the prescaler. Each channel holds its output high from count 0 up to and including its duty value. Because of that, the shortest pulse is one tick and a duty of 255 holds the line high for the whole period.

New duty and prescale values are loaded into working copies only at a period boundary. A write therefore never produces a cut or stretched pulse.

Top module: `pwm_multi`

## Requirements
- R1: After reset every register reads zero and every output is low.
- R2: Offset 0x50 stores bits 3:0 (prescale low nibble), bit 9 (run) and bits 14:11 (prescale high nibble), and its other bits read zero. Offset 0x54 stores bit 0 only. Offset 4*n stores the 8-bit duty of channel n in bits 7:0, and its upper bits read zero.
- R3: A write to any other offset changes no register and no output, and a read from such an offset returns zero.
- R4: With duty N, a channel is high for N+1 ticks of each 256-tick period, starting at count 0. A duty of 0 gives a single high tick.
- R5: A duty of 255 keeps the output high continuously.
- R6: The prescale value p is formed as {bits 14:11, bits 3:0} of offset 0x50. One tick lasts p+1 clock cycles, so a period lasts 256*(p+1) cycles.
- R7: While the run bit is clear, every output is low and the count is held at zero. Setting the run bit starts a period at count 0 in the very next cycle.
- R8: A duty or prescale write made while running takes effect at the next wrap of the count from 255 to 0. A write in the wrap cycle itself applies to the period that wrap starts. Values written in the cycle that sets the run bit apply from the first period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, together with bus_sel |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | CH | Channel outputs |

## Verification
The collision that matters is a duty register write landing in the same cycle as the count wrapping from 255 to 0. In that cycle the working copy loads, and it must pick up the value being written, not the old one. The bench times a duty write so that it is sampled exactly on a wrap edge. It then measures the high time of the period that wrap starts, which must already reflect the new duty. A second case writes a lower duty part way through a high phase, and the output must stay high until the old duty is reached.

// File: rtl/pwm_multi.sv
module pwm_multi #(
  parameter int CH = 1,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [CH-1:0] pwm_out
);
  localparam logic [AW-1:0] CTRL_A = AW'(8'h50);
  localparam logic [AW-1:0] IEN_A  = AW'(8'h54);

  logic [7:0]          presc_q, presc_nx, presc_act;
  logic                run_q, ien_q;
  logic [CH-1:0][7:0]  duty_q, duty_nx, duty_act;
  logic [7:0]          div_q, cnt_q;
  logic                wr, hit_ctrl, hit_ien, hit_duty, tick, wrap;
  logic [AW-3:0]       idx;

  assign wr       = bus_sel & bus_we;
  assign idx      = bus_addr[AW-1:2];
  assign hit_ctrl = bus_addr == CTRL_A;
  assign hit_ien  = bus_addr == IEN_A;
  assign hit_duty = (bus_addr[1:0] == 2'b00) && (bus_addr < CTRL_A) && (int'(idx) < CH);
  assign tick     = div_q == presc_act;
  assign wrap     = tick && (cnt_q == 8'hFF);

  assign presc_nx = (wr && hit_ctrl) ? {bus_wdata[14:11], bus_wdata[3:0]} : presc_q;

  always_comb begin
    for (int i = 0; i < CH; i++)
      duty_nx[i] = (wr && hit_duty && int'(idx) == i) ? bus_wdata[7:0] : duty_q[i];
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)
      bus_rdata = {17'b0, presc_q[7:4], 1'b0, run_q, 5'b0, presc_q[3:0]};
    else if (hit_ien)
      bus_rdata = {31'b0, ien_q};
    else if (hit_duty)
      for (int i = 0; i < CH; i++)
        if (int'(idx) == i) bus_rdata = {24'b0, duty_q[i]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= '0;
      run_q   <= 1'b0;
      ien_q   <= 1'b0;
      duty_q  <= '0;
    end else begin
      presc_q <= presc_nx;
      duty_q  <= duty_nx;
      if (wr && hit_ctrl) run_q <= bus_wdata[9];
      if (wr && hit_ien)  ien_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q     <= '0;
      cnt_q     <= '0;
      presc_act <= '0;
      duty_act  <= '0;
    end else if (!run_q) begin
      div_q     <= '0;
      cnt_q     <= '0;
      presc_act <= presc_nx;
      duty_act  <= duty_nx;
    end else begin
      if (tick) begin
        div_q <= '0;
        cnt_q <= cnt_q + 8'd1;
      end else begin
        div_q <= div_q + 8'd1;
      end
      if (wrap) begin
        presc_act <= presc_nx;
        duty_act  <= duty_nx;
      end
    end
  end

  for (genvar g = 0; g < CH; g++) begin : g_ch
    assign pwm_out[g] = run_q && (cnt_q <= duty_act[g]);
  end
endmodule

// File: rtl/pwm_multi_chk.sv
module pwm_multi_chk #(
  parameter int CH = 1,
  parameter int AW = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_we,
  input logic [AW-1:0]      bus_addr,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic [CH-1:0]      pwm_out,
  input logic               run_q,
  input logic [7:0]         div_q,
  input logic [7:0]         cnt_q,
  input logic [7:0]         presc_act,
  input logic [CH-1:0][7:0] duty_act
);
  logic mapped;
  assign mapped = (bus_addr == AW'(8'h50)) || (bus_addr == AW'(8'h54)) ||
                  ((bus_addr[1:0] == 2'b00) && (int'(bus_addr) < 4 * CH));

  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == 32'h0);

  assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_addr == AW'(8'h50) && !bus_wdata[9]) |=> pwm_out == '0);

  assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> (cnt_q == 8'h0 && div_q == 8'h0));

  assert_period_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && div_q == presc_act && cnt_q == 8'hFF) |=> (!run_q || pwm_out == {CH{1'b1}}));

  assert_no_midload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !(div_q == presc_act && cnt_q == 8'hFF)) |=> ($stable(duty_act) && $stable(presc_act)));

  assert_tick_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && div_q != presc_act) |=> (!run_q || $stable(cnt_q)));
endmodule

bind pwm_multi pwm_multi_chk #(.CH(CH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pwm_out(pwm_out), .run_q(run_q), .div_q(div_q), .cnt_q(cnt_q),
  .presc_act(presc_act), .duty_act(duty_act)
);

// File: tb/pwm_multi_tb.sv
`timescale 1ns/1ps
module pwm_multi_tb;
  localparam int CH = 2;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [CH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { int hi; int per; string tag; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  pwm_multi #(.CH(CH), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic expect_pulse(input int hi, input int per, input string tag);
    item_t it;
    it.hi = hi; it.per = per; it.tag = tag;
    q.push_back(it);
  endtask

  logic prev0 = 1'b0;
  bit   active = 1'b0;
  int   hcnt = 0, pcnt = 0;
  always @(negedge clk) begin
    logic cur;
    item_t it;
    cur = pwm_out[0];
    if (cur && !prev0) begin
      if (active) begin
        it = q.pop_front();
        checks++;
        if (hcnt != it.hi || pcnt != it.per) begin
          errors++;
          $display("FAIL %s high/period actual=%0d/%0d expected=%0d/%0d",
                   it.tag, hcnt, pcnt, it.hi, it.per);
        end
        active = 1'b0;
      end
      if (q.size() > 0) begin
        active = 1'b1; hcnt = 1; pcnt = 1;
      end
    end else if (active) begin
      pcnt++;
      if (cur) hcnt++;
    end
    prev0 = cur;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int bad;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h50, d); check("R1 ctrl", d, 32'h0);
    rd(8'h54, d); check("R1 ien", d, 32'h0);
    rd(8'h00, d); check("R1 duty0", d, 32'h0);
    rd(8'h04, d); check("R1 duty1", d, 32'h0);
    check("R1 outputs", {30'b0, pwm_out}, 32'h0);
    @(negedge clk);

    // R4: duty 10 on ch0, duty 0 on ch1
    wr(8'h00, 32'hFFFF_FF0A);
    wr(8'h04, 32'h0);
    rd(8'h00, d); check("R2 duty mask", d, 32'h0000_000A);
    @(negedge clk);
    expect_pulse(11, 256, "R4 duty10");
    wr(8'h50, 32'h200);
    check("R7 start high ch1", {31'b0, pwm_out[1]}, 32'h1);
    @(negedge clk);
    check("R4 duty0 single tick ch1", {31'b0, pwm_out[1]}, 32'h0);
    wait (q.size() == 0);

    // R8: write landing on the wrap edge applies to the new period
    expect_pulse(41, 256, "R8 wrap collision");
    repeat (255) @(negedge clk);
    wr(8'h00, 32'd40);
    wait (q.size() == 0);

    // R8: mid-period lower duty keeps current pulse
    wr(8'h00, 32'd3);
    repeat (10) @(negedge clk);
    check("R8 mid-period hold", {31'b0, pwm_out[0]}, 32'h1);
    expect_pulse(4, 256, "R8 next period");
    wait (q.size() == 0);

    // R7 stop
    @(negedge clk);
    wr(8'h50, 32'h0);
    check("R7 stopped outputs", {30'b0, pwm_out}, 32'h0);

    // R6 prescale 0x13
    wr(8'h00, 32'd2);
    wr(8'h50, 32'h0803);
    rd(8'h50, d); check("R2 ctrl readback", d, 32'h0000_0803);
    @(negedge clk);
    check("R7 idle low", {30'b0, pwm_out}, 32'h0);
    expect_pulse(60, 5120, "R6 prescale 19");
    wr(8'h50, 32'h0A03);
    wait (q.size() == 0);

    // R5 duty 255
    @(negedge clk);
    wr(8'h50, 32'h0);
    wr(8'h00, 32'd255);
    wr(8'h50, 32'h200);
    bad = 0;
    for (int i = 0; i < 600; i++) begin
      if (pwm_out[0] !== 1'b1) bad++;
      @(negedge clk);
    end
    check("R5 never low", bad, 0);
    wr(8'h50, 32'h0);

    // R3 unmapped offsets
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h4C, 32'hFFFF_FFFF);
    rd(8'h08, d); check("R3 read unmapped", d, 32'h0);
    rd(8'h00, d); check("R3 duty0 untouched", d, 32'd255);
    rd(8'h04, d); check("R3 duty1 untouched", d, 32'h0);
    rd(8'h50, d); check("R3 ctrl untouched", d, 32'h0);
    check("R3 outputs untouched", {30'b0, pwm_out}, 32'h0);
    @(negedge clk);

    // R2 masks
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h54, d); check("R2 ien bit0", d, 32'h1);
    @(negedge clk);
    wr(8'h50, 32'hFFFF_FFFF);
    rd(8'h50, d); check("R2 ctrl fields", d, 32'h0000_7A0F);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule